// File: doc/BRIEF.md
# Lockable Multicart PRG Bank Mapper

This block is the banking register of an 8-bit console cartridge that holds up to 1 MiB of program ROM. Any CPU write into the upper half of the CPU address space loads the register, and both the write address and the write data carry fields. The written data is taken as it is, with no masking against ROM contents. From the stored fields and the live CPU address, the block drives the upper PRG ROM address lines A19..A14, an override that can force PRG A1 high, and the nametable select that goes to CIRAM A10.

A mode bit and a transparency bit together choose one of four layouts:

- a UNROM-like layout whose upper 16 KiB window is fixed to the last bank of the outer block;
- the same layout with the latch lsb ignored;
- a single 16 KiB bank mirrored into both windows;
- a 32 KiB window.

A lock bit freezes every field except the inner bank. After that, only the inner bank selection can change, until the next reset.

Top module: `prg_bank_mapper`

## Requirements
- R1: The register loads on a rising clock edge where `cpu_wr` is 1 and `cpu_addr[15]` is 1. A write with `cpu_addr[15]` at 0 changes no output.
- R2: The fields are taken from the write as follows:
  - `cpu_addr[0]` is the type bit, `cpu_addr[1]` is the lock bit, and `cpu_addr[2]` is the outer bank msb.
  - `cpu_data[2:0]` is the inner bank, and `cpu_data[4:3]` are the two low outer bank bits.
  - `cpu_data[5]` is the mirroring bit, `cpu_data[6]` is transparency and `cpu_data[7]` is mode.
  - `prg_hi[5:3]` (PRG A19..A17) equals {`cpu_addr[2]`, `cpu_data[4]`, `cpu_data[3]`}.
- R3: With mode 0 and transparency 0, `prg_hi[2:0]` is the inner bank ORed bitwise with `cpu_addr[14]` on all three bits. This gives the inner bank in the lower window and 7 in the upper window.
- R4: With mode 0 and transparency 1, the behaviour is as in R3, except that inner bank bit 0 is taken as 0 before the OR.
- R5: With mode 1 and transparency 0, `prg_hi[2:0]` is the inner bank and `cpu_addr[14]` has no effect.
- R6: With mode 1 and transparency 1, `prg_hi[2:1]` is inner bank bits 2..1 and `prg_hi[0]` follows `cpu_addr[14]`.
- R7: While the lock bit is 1, a loading write updates only the inner bank. Every other field, the lock bit included, keeps its value.
- R8: `prg_a1` is 1 when the type bit is 1, and equals `cpu_addr[1]` otherwise.
- R9: `ciram_a10` equals `ppu_a10` when the mirroring bit is 1, and equals `ppu_a11` when it is 0.
- R10: A synchronous reset clears every field to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address (write fields and live A14/A1) |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| prg_hi | output | 6 | PRG ROM address A19..A14 |
| prg_a1 | output | 1 | PRG ROM address A1 |
| ciram_a10 | output | 1 | Nametable RAM A10 select |

## Verification
All 2048 combinations of the three address field bits and the eight data bits are loaded from reset. Each one is read back with both values of CPU A14 and A1 and all four PPU A10/A11 pairs. This sweep separates the four layouts, because only the layouts differ in how A14 and the latch lsb reach the bank lines. Locked pairs of writes with complementary second values show that only the inner bank moves. Low-half writes show that the address decode rejects them, and a reset after a busy state shows that every field clears.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic        ppu_a10,
  input  logic        ppu_a11,
  output logic [5:0]  prg_hi,
  output logic        prg_a1,
  output logic        ciram_a10
);

  logic [2:0] inner_q, outer_q;
  logic       mirror_q, transp_q, mode_q, lock_q, type_q;
  logic [2:0] low_bank;
  logic       load;

  wire unused_addr = ^{cpu_addr[13:3]};

  assign load = cpu_wr && cpu_addr[15];

  always_ff @(posedge clk) begin
    if (rst) begin
      inner_q  <= '0;
      outer_q  <= '0;
      mirror_q <= 1'b0;
      transp_q <= 1'b0;
      mode_q   <= 1'b0;
      lock_q   <= 1'b0;
      type_q   <= 1'b0;
    end else if (load) begin
      inner_q <= cpu_data[2:0];
      if (!lock_q) begin
        outer_q  <= {cpu_addr[2], cpu_data[4:3]};
        mirror_q <= cpu_data[5];
        transp_q <= cpu_data[6];
        mode_q   <= cpu_data[7];
        lock_q   <= cpu_addr[1];
        type_q   <= cpu_addr[0];
      end
    end
  end

  always_comb begin
    case ({mode_q, transp_q})
      2'b00:   low_bank = inner_q | {3{cpu_addr[14]}};
      2'b01:   low_bank = {inner_q[2:1], 1'b0} | {3{cpu_addr[14]}};
      2'b10:   low_bank = inner_q;
      default: low_bank = {inner_q[2:1], cpu_addr[14]};
    endcase
  end

  assign prg_hi    = {outer_q, low_bank};
  assign prg_a1    = type_q | cpu_addr[1];
  assign ciram_a10 = mirror_q ? ppu_a10 : ppu_a11;

  assert_locked_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (load && lock_q) |=> $stable({outer_q, mirror_q, transp_q, mode_q, lock_q, type_q}));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({inner_q, outer_q, mirror_q, transp_q, mode_q, lock_q, type_q}));

  assert_fixed_top_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && cpu_addr[14]) |-> (prg_hi[2:0] == 3'b111));

  assert_a1_pass_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_addr[1] |-> prg_a1);

  assert_mirror_src_R9: assert property (@(posedge clk) disable iff (rst)
    (ppu_a10 == ppu_a11) |-> (ciram_a10 == ppu_a10));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (lock_q == 1'b0 && mode_q == 1'b0));

endmodule

// File: tb/test_prg_bank_mapper.sv
`timescale 1ns/1ps
module test_prg_bank_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_data = 8'h0;
  logic        cpu_wr = 1'b0;
  logic        ppu_a10 = 1'b0, ppu_a11 = 1'b0;
  logic [5:0]  prg_hi;
  logic        prg_a1, ciram_a10;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  prg_bank_mapper i_prg_bank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
    .prg_hi(prg_hi), .prg_a1(prg_a1), .ciram_a10(ciram_a10));

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  function automatic string map_tag(input logic [7:0] d);
    case (d[7:6])
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // Expected state is given by the address field bits al and data d of the effective write.
  task automatic check_all(input string tag, input logic [2:0] al, input logic [7:0] d);
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      logic a14, a1;
      int bank;
      logic [5:0] ehi;
      logic ea1, ecir;
      a14 = k[0]; a1 = k[1];
      cpu_addr = {1'b1, a14, 12'h000, a1, 1'b0};
      ppu_a10 = k[2]; ppu_a11 = k[3];
      #0.1;
      if (!d[7]) begin
        if (a14) bank = 7;
        else if (d[6]) bank = (int'(d[2:0]) / 2) * 2;
        else bank = int'(d[2:0]);
      end else begin
        if (d[6]) bank = (int'(d[2:0]) / 2) * 2 + int'(a14);
        else bank = int'(d[2:0]);
      end
      ehi  = 6'(((int'(al[2]) * 4 + int'(d[4:3])) * 8) + bank);
      ea1  = al[0] ? 1'b1 : a1;
      ecir = d[5] ? ppu_a10 : ppu_a11;
      checks++;
      if (prg_hi !== ehi) begin
        fails++;
        $display("FAIL %s/R2 prg_hi actual=%h expected=%h (al=%b d=%h a14=%b)", tag, prg_hi, ehi, al, d, a14);
      end
      checks++;
      if (prg_a1 !== ea1) begin
        fails++;
        $display("FAIL R8 prg_a1 actual=%b expected=%b (al=%b a1=%b)", prg_a1, ea1, al, a1);
      end
      checks++;
      if (ciram_a10 !== ecir) begin
        fails++;
        $display("FAIL R9 ciram_a10 actual=%b expected=%b (d=%h)", ciram_a10, ecir, d);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    check_all("R10", 3'b000, 8'h00);

    // R2..R6, R8, R9: full sweep of field bits from reset
    for (int al = 0; al < 8; al++)
      for (int d = 0; d < 256; d++) begin
        do_reset();
        do_write(16'h8000 | 16'(al), 8'(d));
        check_all(map_tag(8'(d)), 3'(al), 8'(d));
      end

    // R7: locked register accepts only the inner bank
    for (int i = 0; i < 32; i++) begin
      logic [2:0] al;
      logic [7:0] d1, d2;
      al = {i[2], 1'b1, i[3]};
      d1 = 8'(i * 37 + 5);
      d2 = ~d1;
      do_reset();
      do_write(16'hC000 | 16'(al), d1);
      do_write(16'hFFF8 | 16'(~al), d2);
      check_all("R7", al, {d1[7:3], d2[2:0]});
    end

    // R1: writes below 0x8000 are ignored
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d1;
      d1 = 8'(i * 53 + 9);
      do_reset();
      do_write(16'h8000 | 16'(i % 8), d1);
      do_write(16'h7FFF - 16'(i), ~d1);
      check_all("R1", 3'(i % 8), d1);
    end

    // R10: reset after a busy locked state clears all fields
    do_write(16'h8007, 8'hFF);
    do_reset();
    check_all("R10", 3'b000, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule